// File: doc/BRIEF.md
# Staged Software-Loaded Translation Buffer

This block is a small fully associative address translation buffer. Software never writes an entry directly. It loads staging registers first: an effective-page register with the page number, a valid flag and an address-space tag, and an attribute register with the page size, the guarded and write-through flags and a segment-valid flag. A control register holds the slot index. Writing the real-page register is the trigger. The three staged values and the written real page are merged into one entry, which is stored at the slot named by the control register.

A separate context register holds the current address-space tag. A lookup compares the request address against every entry in parallel. Only the page-number bits that the entry's page size covers take part in the compare. The result is registered: hit, physical address, guarded and write-through appear one cycle after the request. When a lookup misses, the effective-page register captures the missing page number, so that software can read it back and refill the buffer.

Top module: `xtlb_top`

## Requirements
- R1: After reset, the control register reads 0x04000000, the context reads 0, `lk_done` and `lk_hit` are low, and every lookup misses until an entry has been committed.
- R2: A write with `reg_wr_sel`=4 (real page, page number in bits 31:12) commits an entry at the index held in control bits 12:8. Writes to control (0), context (1), effective page (2) or attribute (3) create no entry.
- R3: An entry can hit only if the effective-page valid bit (bit 9) and the attribute segment-valid bit (bit 0) were both 1 when the entry was committed.
- R4: An entry hits only when its address-space tag (effective-page bits 3:0) equals the context register bits 3:0 at the time of the request.
- R5: The attribute size field (bits 3:2) sets how many address bits are compared. 00 compares address bits 31:12 (4 KB pages). 01 compares bits 31:19 (512 KB). 11 compares bits 31:23 (8 MB). The unused code 10 acts as 4 KB.
- R6: On a hit, the physical address takes the real page bits above the page offset and the request address bits inside the offset. On a miss, `lk_paddr`, `lk_guarded` and `lk_wthru` are 0.
- R7: On a hit, `lk_guarded` returns attribute bit 4 and `lk_wthru` returns attribute bit 1 of the matching entry.
- R8: `lk_done` is high exactly one cycle after each cycle with `lk_req` high. `lk_hit` can be high only together with `lk_done`.
- R9: After a lookup miss, the effective-page register holds the request address bits 31:12 in bits 31:12, a 0 in bit 9 and the context tag in bits 3:0. A software write to that register in the same cycle takes precedence.
- R10: A commit to an index that is already in use replaces the old entry.
- R11: When several entries match, the entry with the lowest index wins.
- R12: `reg_rd_data` is registered and returns the register named by `reg_rd_sel` one cycle later. Context returns only bits 3:0. Effective page returns bits 31:12, 9 and 3:0. Attribute returns bits 4:0. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Write target: 0 control, 1 context, 2 effective page, 3 attribute, 4 real page |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 3 | Read source, same encoding as the write target |
| reg_rd_data | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup effective address |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address |
| lk_guarded | output | 1 | Guarded attribute of the hit |
| lk_wthru | output | 1 | Write-through attribute of the hit |

## Verification
The bench targets the size-dependent compare. It uses an 8 MB entry whose staged page and real page carry stray low bits. A design that masked the wrong field would miss that entry, or would leak the stray bits into the physical address. It also probes the edge of a 512 KB page, where a mask one bit too narrow would still hit. Two entries that both match test the priority rule: a design that picked the highest index would return the wrong real page. The bench also checks that a tag mismatch or a cleared valid flag blocks a hit, and that staging writes alone never create an entry. After a miss it reads the captured page number back, which catches a design that left stale contents in the register or set its valid bit.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int PN_W   = VA_W - OFS_W;
  localparam int ASID_W = 4;

  localparam logic [31:0] CTRL_RST     = 32'h0400_0000;
  localparam int          CTRL_IDX_LSB = 8;
  localparam int          EPN_VLD_BIT  = 9;

  localparam int ATTR_SV_BIT = 0;
  localparam int ATTR_WT_BIT = 1;
  localparam int ATTR_SZ_LSB = 2;
  localparam int ATTR_G_BIT  = 4;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_CTX  = 3'd1;
  localparam logic [2:0] SEL_EPN  = 3'd2;
  localparam logic [2:0] SEL_ATTR = 3'd3;
  localparam logic [2:0] SEL_RPN  = 3'd4;

  typedef enum logic [1:0] {
    SZ_4K   = 2'b00,
    SZ_512K = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_8M   = 2'b11
  } pg_size_e;

  typedef struct packed {
    logic [PN_W-1:0]   epn;
    logic [ASID_W-1:0] asid;
    pg_size_e          psize;
    logic              guarded;
    logic              wthru;
    logic [PN_W-1:0]   rpn;
  } xtlb_entry_t;

  // Page-number bits that take part in the compare, per page size.
  function automatic logic [PN_W-1:0] page_mask(input pg_size_e sz);
    logic [PN_W-1:0] m;
    case (sz)
      SZ_512K: m = {{(PN_W-7){1'b1}}, 7'b0};
      SZ_8M:   m = {{(PN_W-11){1'b1}}, 11'b0};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xtlb_stage_regs.sv
module xtlb_stage_regs
  import xtlb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              miss_cap,
  input  logic [PN_W-1:0]   miss_vpn,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output xtlb_entry_t       commit_ent,
  output logic              commit_live,
  output logic [ASID_W-1:0] ctx_asid,
  output logic [31:0]       epn_q
);
  logic [31:0]       ctrl_q;
  logic [ASID_W-1:0] ctx_q;
  logic [4:0]        attr_q;
  logic [PN_W-1:0]   rpn_q;
  logic              wr_ctrl, wr_ctx, wr_epn, wr_attr, wr_rpn;
  logic [31:0]       epn_wmask;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_ctx  = wr_en && (wr_sel == SEL_CTX);
  assign wr_epn  = wr_en && (wr_sel == SEL_EPN);
  assign wr_attr = wr_en && (wr_sel == SEL_ATTR);
  assign wr_rpn  = wr_en && (wr_sel == SEL_RPN);

  assign epn_wmask = {{PN_W{1'b1}}, 2'b00, 1'b1, 5'b0, {ASID_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      ctx_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_ctx)  ctx_q  <= wr_data[ASID_W-1:0];
    end
  end

  // Staging registers carry no defined reset value.
  always_ff @(posedge clk) begin
    if (wr_epn)
      epn_q <= wr_data & epn_wmask;
    else if (miss_cap)
      epn_q <= {miss_vpn, 2'b00, 1'b0, 5'b0, ctx_q};
    if (wr_attr) attr_q <= wr_data[4:0];
    if (wr_rpn)  rpn_q  <= wr_data[31:OFS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_CTRL: rd_data <= ctrl_q;
        SEL_CTX:  rd_data <= {{(32-ASID_W){1'b0}}, ctx_q};
        SEL_EPN:  rd_data <= epn_q;
        SEL_ATTR: rd_data <= {27'b0, attr_q};
        SEL_RPN:  rd_data <= {rpn_q, {OFS_W{1'b0}}};
        default:  rd_data <= '0;
      endcase
    end
  end

  assign commit      = wr_rpn;
  assign commit_idx  = ctrl_q[CTRL_IDX_LSB +: IDX_W];
  assign commit_live = epn_q[EPN_VLD_BIT] && attr_q[ATTR_SV_BIT];
  assign ctx_asid    = ctx_q;

  always_comb begin
    commit_ent.epn     = epn_q[31:OFS_W];
    commit_ent.asid    = epn_q[ASID_W-1:0];
    commit_ent.psize   = pg_size_e'(attr_q[ATTR_SZ_LSB +: 2]);
    commit_ent.guarded = attr_q[ATTR_G_BIT];
    commit_ent.wthru   = attr_q[ATTR_WT_BIT];
    commit_ent.rpn     = wr_data[31:OFS_W];
  end
endmodule

// File: rtl/xtlb_entry_array.sv
module xtlb_entry_array
  import xtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [IDX_W-1:0]  commit_idx,
  input  xtlb_entry_t       commit_ent,
  input  logic              commit_live,
  input  logic [PN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0] ctx_asid,
  output logic [ENTRIES-1:0] match_o,
  output xtlb_entry_t       ent_q [ENTRIES]
);
  logic [ENTRIES-1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else if (commit) live_q[commit_idx] <= commit_live;
  end

  // Payload has no reset so it can map onto distributed memory.
  always_ff @(posedge clk) begin
    if (commit) ent_q[commit_idx] <= commit_ent;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [PN_W-1:0] cmp_mask;
    assign cmp_mask   = page_mask(ent_q[e].psize);
    assign match_o[e] = live_q[e] && (ent_q[e].asid == ctx_asid) &&
                        (((ent_q[e].epn ^ lk_vpn) & cmp_mask) == '0);
  end
endmodule

// File: rtl/xtlb_lookup.sv
module xtlb_lookup
  import xtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [ENTRIES-1:0] match_i,
  input  xtlb_entry_t        ent_i [ENTRIES],
  output logic               miss_cap,
  output logic               done,
  output logic               hit,
  output logic [VA_W-1:0]    paddr,
  output logic               guarded,
  output logic               wthru
);
  logic             any_c;
  logic [IDX_W-1:0] win_c;
  xtlb_entry_t      sel_c;
  logic [VA_W-1:0]  amask_c;
  logic [VA_W-1:0]  pa_c;

  // Lowest matching index wins.
  always_comb begin
    any_c = 1'b0;
    win_c = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_c = 1'b1;
        win_c = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_c   = ent_i[win_c];
    amask_c = {page_mask(sel_c.psize), {OFS_W{1'b0}}};
    pa_c    = ({sel_c.rpn, {OFS_W{1'b0}}} & amask_c) | (vaddr & ~amask_c);
  end

  assign miss_cap = req && !any_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      hit     <= 1'b0;
      paddr   <= '0;
      guarded <= 1'b0;
      wthru   <= 1'b0;
    end else begin
      done    <= req;
      hit     <= req && any_c;
      paddr   <= (req && any_c) ? pa_c : '0;
      guarded <= req && any_c && sel_c.guarded;
      wthru   <= req && any_c && sel_c.wthru;
    end
  end
endmodule

// File: rtl/xtlb_top.sv
module xtlb_top
  import xtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic [2:0]  reg_rd_sel,
  output logic [31:0] reg_rd_data,
  input  logic        lk_req,
  input  logic [31:0] lk_addr,
  output logic        lk_done,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  output logic        lk_guarded,
  output logic        lk_wthru
);
  logic               commit, commit_live, miss_cap, epn_wr;
  logic [IDX_W-1:0]   commit_idx;
  xtlb_entry_t        commit_ent;
  logic [ASID_W-1:0]  ctx_asid;
  logic [31:0]        stage_epn;
  logic [ENTRIES-1:0] match_vec;
  xtlb_entry_t        ents [ENTRIES];

  assign epn_wr = reg_wr_en && (reg_wr_sel == SEL_EPN);

  xtlb_stage_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .miss_cap(miss_cap), .miss_vpn(lk_addr[31:OFS_W]),
    .commit(commit), .commit_idx(commit_idx), .commit_ent(commit_ent),
    .commit_live(commit_live), .ctx_asid(ctx_asid), .epn_q(stage_epn)
  );

  xtlb_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst(rst),
    .commit(commit), .commit_idx(commit_idx), .commit_ent(commit_ent),
    .commit_live(commit_live), .lk_vpn(lk_addr[31:OFS_W]),
    .ctx_asid(ctx_asid), .match_o(match_vec), .ent_q(ents)
  );

  xtlb_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk (
    .clk(clk), .rst(rst),
    .req(lk_req), .vaddr(lk_addr), .match_i(match_vec), .ent_i(ents),
    .miss_cap(miss_cap), .done(lk_done), .hit(lk_hit), .paddr(lk_paddr),
    .guarded(lk_guarded), .wthru(lk_wthru)
  );
endmodule

// File: rtl/xtlb_chk.sv
module xtlb_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_req,
  input logic [31:0] lk_addr,
  input logic        lk_done,
  input logic        lk_hit,
  input logic [31:0] lk_paddr,
  input logic        lk_guarded,
  input logic        lk_wthru,
  input logic [31:0] stage_epn,
  input logic        epn_wr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_done && !lk_hit));

  // R8
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_done);

  // R8
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_done);

  // R8
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == 32'h0 && !lk_guarded && !lk_wthru));

  // R9
  miss_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit && !$past(epn_wr)) |->
      (stage_epn[31:12] == $past(lk_addr[31:12]) && !stage_epn[9]));
endmodule

bind xtlb_top xtlb_chk u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_addr(lk_addr),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .lk_guarded(lk_guarded), .lk_wthru(lk_wthru),
  .stage_epn(stage_epn), .epn_wr(epn_wr)
);

// File: tb/sim_xtlb_top.sv
`timescale 1ns/1ps
module sim_xtlb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic [2:0]  reg_rd_sel;
  logic [31:0] reg_rd_data;
  logic        lk_req;
  logic [31:0] lk_addr;
  logic        lk_done, lk_hit, lk_guarded, lk_wthru;
  logic [31:0] lk_paddr;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  xtlb_top u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_guarded(lk_guarded), .lk_wthru(lk_wthru)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    reg_rd_sel = sel;
    @(negedge clk);
    data = reg_rd_data;
  endtask

  task automatic load(input int idx, input logic [19:0] epn, input bit v, input logic [3:0] asid,
                      input logic [1:0] sz, input bit g, input bit wt, input bit sv,
                      input logic [19:0] rpn);
    reg_write(3'd0, 32'h0400_0000 | (32'(idx) << 8));
    reg_write(3'd2, {epn, 2'b00, v, 5'b0, asid});
    reg_write(3'd3, {27'b0, g, sz, wt, sv});
    reg_write(3'd4, {rpn, 12'h000});
  endtask

  task automatic look(input logic [31:0] addr, input bit exp_hit, input logic [31:0] exp_pa,
                      input bit exp_g, input bit exp_wt, input string tag);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = addr;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_done === 1'b1, {tag, " R8 done"}, 32'(lk_done), 32'd1);
    chk(lk_hit === exp_hit, {tag, " hit"}, 32'(lk_hit), 32'(exp_hit));
    chk(lk_paddr === exp_pa, {tag, " R6 paddr"}, lk_paddr, exp_pa);
    chk({lk_guarded, lk_wthru} === {exp_g, exp_wt}, {tag, " R7 attr"},
        32'({lk_guarded, lk_wthru}), 32'({exp_g, exp_wt}));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(lk_done === 1'b0 && lk_hit === 1'b0, "R1 outputs idle", 32'({lk_done, lk_hit}), 32'd0);
    reg_read(3'd0, d);
    chk(d === 32'h0400_0000, "R1 control reset", d, 32'h0400_0000);
    reg_read(3'd1, d);
    chk(d === 32'h0, "R1 context reset", d, 32'h0);
    look(32'h0000_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R1 empty lookup");
    @(negedge clk);
    chk(lk_done === 1'b0, "R8 done drops when idle", 32'(lk_done), 32'd0);
  endtask

  task automatic t_staging_only;
    logic [31:0] d;
    reg_write(3'd1, 32'hFFFF_FFFF);
    reg_write(3'd2, 32'hFFFF_FFFF);
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd1, d);
    chk(d === 32'h0000_000F, "R12 context readback", d, 32'h0000_000F);
    reg_read(3'd2, d);
    chk(d === 32'hFFFF_F20F, "R12 epn readback", d, 32'hFFFF_F20F);
    reg_read(3'd3, d);
    chk(d === 32'h0000_001F, "R12 attr readback", d, 32'h0000_001F);
    look(32'hFFFF_F000, 1'b0, 32'h0, 1'b0, 1'b0, "R2 no entry without real-page write");
  endtask

  task automatic t_basic;
    reg_write(3'd1, 32'h5);
    load(3, 20'h12345, 1'b1, 4'h5, 2'b00, 1'b1, 1'b0, 1'b1, 20'hABCDE);
    look(32'h1234_5678, 1'b1, 32'hABCD_E678, 1'b1, 1'b0, "R2 4K commit hit");
    look(32'h1234_6000, 1'b0, 32'h0, 1'b0, 1'b0, "R5 4K neighbour miss");
  endtask

  task automatic t_asid;
    reg_write(3'd1, 32'h6);
    look(32'h1234_5678, 1'b0, 32'h0, 1'b0, 1'b0, "R4 tag mismatch");
    reg_write(3'd1, 32'h5);
    look(32'h1234_5678, 1'b1, 32'hABCD_E678, 1'b1, 1'b0, "R4 tag restored");
  endtask

  task automatic t_valid_bits;
    load(4, 20'h20000, 1'b0, 4'h5, 2'b00, 1'b0, 1'b0, 1'b1, 20'h00111);
    look(32'h2000_0010, 1'b0, 32'h0, 1'b0, 1'b0, "R3 page valid clear");
    load(5, 20'h21000, 1'b1, 4'h5, 2'b00, 1'b0, 1'b0, 1'b0, 20'h00222);
    look(32'h2100_0010, 1'b0, 32'h0, 1'b0, 1'b0, "R3 segment valid clear");
  endtask

  task automatic t_sizes;
    load(6, 20'h40000, 1'b1, 4'h5, 2'b01, 1'b0, 1'b1, 1'b1, 20'h80000);
    look(32'h4007_1234, 1'b1, 32'h8007_1234, 1'b0, 1'b1, "R5 512K inside");
    look(32'h4008_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R5 512K edge miss");
    load(7, 20'h60123, 1'b1, 4'h5, 2'b11, 1'b1, 1'b1, 1'b1, 20'h01234);
    look(32'h605A_BCDE, 1'b1, 32'h015A_BCDE, 1'b1, 1'b1, "R5 8M masked compare");
    load(8, 20'h70001, 1'b1, 4'h5, 2'b10, 1'b0, 1'b0, 1'b1, 20'h00055);
    look(32'h7000_1ABC, 1'b1, 32'h0005_5ABC, 1'b0, 1'b0, "R5 code 10 as 4K");
    look(32'h7000_0ABC, 1'b0, 32'h0, 1'b0, 1'b0, "R5 code 10 neighbour miss");
  endtask

  task automatic t_overwrite;
    load(3, 20'h12345, 1'b1, 4'h5, 2'b00, 1'b0, 1'b1, 1'b1, 20'h11111);
    look(32'h1234_5678, 1'b1, 32'h1111_1678, 1'b0, 1'b1, "R10 overwrite");
  endtask

  task automatic t_priority;
    load(2, 20'h90000, 1'b1, 4'h5, 2'b00, 1'b0, 1'b0, 1'b1, 20'h00BBB);
    load(1, 20'h90000, 1'b1, 4'h5, 2'b00, 1'b0, 1'b0, 1'b1, 20'h00AAA);
    look(32'h9000_0004, 1'b1, 32'h00AA_A004, 1'b0, 1'b0, "R11 lowest index");
  endtask

  task automatic t_miss_capture;
    logic [31:0] d;
    reg_write(3'd1, 32'h5);
    look(32'hDEAD_B123, 1'b0, 32'h0, 1'b0, 1'b0, "R9 miss");
    reg_read(3'd2, d);
    chk(d === 32'hDEAD_B005, "R9 captured page", d, 32'hDEAD_B005);
  endtask

  initial begin
    rst = 1'b1; reg_wr_en = 1'b0; reg_wr_sel = 3'd0; reg_wr_data = '0;
    reg_rd_sel = 3'd0; lk_req = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_staging_only();
    t_basic();
    t_asid();
    t_valid_bits();
    t_sizes();
    t_overwrite();
    t_priority();
    t_miss_capture();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule